// File: doc/BRIEF.md
# Switch CPU Frame Injection Framer

This block turns a frame presented as a host-side byte stream into the word sequence that a switch CPU injection queue expects. The queue takes two kinds of writes: 32-bit data words and control words that mark the start and end of a frame. The two share one backpressure input. When the first byte of a frame shows up, the framer issues a start control word. It then sends a fixed number of internal-header words taken from a side input, followed by the payload packed four bytes per word.

Short frames are padded with zero words up to a minimum cell of payload words. The framer then issues an end control word that carries the number of valid bytes in the last word. Last comes one all-zero placeholder checksum word. The frame length is never supplied up front. The framer counts bytes as they arrive, and the count is complete at the byte flagged last, which is before the padding and end-of-frame decisions are needed. The contents of the header, real checksum generation and the queue storage are outside this block.

Top module: `inj_framer`

## Requirements
- R1: After reset the block is idle: `busy`, `wr_valid`, `ctl_valid` and `in_ready` are all low.
- R2: When a byte is offered while idle, the first write is a control word with only the start flag (bit 18) and the gap field (bits 23:21 = 1) set, which is 32'h0024_0000. `busy` rises no later than this write.
- R3: The start control word is followed by HDR_WORDS (default 4) data words. They are taken from `hdr_in` as it stands when the start word is accepted, with word k at bits 32k+31:32k.
- R4: Payload bytes are packed in arrival order, with the first byte of each word in bits 7:0. The number of payload words is the byte length rounded up to whole words. Unused bytes of the last word are zero.
- R5: After the payload, zero words follow until 15 payload-plus-pad words have been sent (a 60-byte cell, header not counted). Frames of 57 bytes or more get no padding.
- R6: The end control word sets the end flag (bit 19) and gap 1, with valid bytes in bits 17:16. That field is 0 for frames shorter than 60 bytes and the length modulo 4 otherwise.
- R7: Exactly one all-zero data word follows the end control word. After it is accepted the block returns to idle and `busy` is low in the next cycle.
- R8: While `out_ready` is low, a pending write keeps its strobe and its data unchanged, and the sequence does not advance.
- R9: `wr_valid` and `ctl_valid` are never high together. `in_ready` is high only in the payload phase, and never while a control word is pending.
- R10: `busy` stays high from the start control word until the checksum word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte accepted on this edge when high with in_valid |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final byte of the frame |
| hdr_in | input | 32*HDR_WORDS | Internal-header words, sampled when the start word is accepted |
| out_ready | input | 1 | Queue accepts the pending data or control write |
| wr_valid | output | 1 | Data word write strobe |
| wr_data | output | 32 | Data word |
| ctl_valid | output | 1 | Control word write strobe |
| ctl_data | output | 32 | Control word |
| busy | output | 1 | A frame is in progress |

## Verification
The checker follows the port-level rules on every cycle. The two strobes must never overlap, a stalled write must hold its data, and every strobe must fall inside `busy`. Each control word must carry gap 1 with exactly one of start or end set. An accepted start must lead straight to a data write, and an accepted end must lead to a zero data word. What only the bench's scenarios can show is the content and order of the whole sequence: header capture, byte packing, the number of pad words, and the valid-bytes value at lengths around the 60-byte boundary and at each remainder. The bench predicts these for each frame from its length and compares every accepted write, with and without random backpressure.

// File: rtl/inj_pkg.sv
package inj_pkg;

   localparam int WORD_W     = 32;
   localparam int GAP_W      = 3;
   localparam int GAP_LSB    = 21;
   localparam int EOF_BIT    = 19;
   localparam int SOF_BIT    = 18;
   localparam int VLD_LSB    = 16;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SOF,
      ST_HDR,
      ST_PAY,
      ST_PAD,
      ST_EOF,
      ST_CRC
   } inj_state_e;

   // Build a queue control word from its fields.
   function automatic logic [WORD_W-1:0] ctl_word(input logic [GAP_W-1:0] gap,
                                                  input logic sof,
                                                  input logic eof,
                                                  input logic [1:0] vld);
      logic [WORD_W-1:0] w;
      w = '0;
      w[GAP_LSB +: GAP_W] = gap;
      w[EOF_BIT]          = eof;
      w[SOF_BIT]          = sof;
      w[VLD_LSB +: 2]     = vld;
      return w;
   endfunction

endpackage

// File: rtl/inj_packer.sv
// Gathers bytes into one 32-bit word, first byte in the low lane.
module inj_packer
   import inj_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [7:0]        in_data,
   input  logic              in_last,
   input  logic              take,
   output logic              pk_valid,
   output logic [WORD_W-1:0] pk_word,
   output logic              pk_last,
   output logic [2:0]        pk_nbytes
);

   logic [WORD_W-1:0] acc_q;
   logic [1:0]        lane_q;
   logic              full_q;
   logic              last_q;
   logic [2:0]        nb_q;

   assign in_ready  = en && !full_q;
   assign pk_valid  = full_q;
   assign pk_word   = acc_q;
   assign pk_last   = last_q;
   assign pk_nbytes = nb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         lane_q <= '0;
         full_q <= 1'b0;
         last_q <= 1'b0;
         nb_q   <= '0;
      end else if (take) begin
         full_q <= 1'b0;
         acc_q  <= '0;
      end else if (in_valid && in_ready) begin
         acc_q[{lane_q, 3'b000} +: 8] <= in_data;
         if (lane_q == 2'd3 || in_last) begin
            full_q <= 1'b1;
            last_q <= in_last;
            nb_q   <= {1'b0, lane_q} + 3'd1;
            lane_q <= '0;
         end else begin
            lane_q <= lane_q + 2'd1;
         end
      end
   end

endmodule

// File: rtl/inj_hdr_store.sv
// Holds the internal-header words captured at frame start.
module inj_hdr_store
   import inj_pkg::*;
#(
   parameter int HDR_WORDS = 4,
   localparam int SEL_W    = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cap,
   input  logic [HDR_WORDS*WORD_W-1:0] hdr_in,
   input  logic [SEL_W-1:0]            sel,
   output logic [WORD_W-1:0]           word
);

   logic [WORD_W-1:0] slot_q [HDR_WORDS];

   for (genvar k = 0; k < HDR_WORDS; k++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q[k] <= '0;
         else if (cap)
            slot_q[k] <= hdr_in[k*WORD_W +: WORD_W];
      end
   end

   if (HDR_WORDS == 1) begin : g_one
      logic unused_sel;
      assign unused_sel = sel[0];
      assign word = slot_q[0];
   end else begin : g_many
      assign word = slot_q[sel];
   end

endmodule

// File: rtl/inj_seq.sv
// Frame sequencer: start, header, payload, pad, end, checksum.
module inj_seq
   import inj_pkg::*;
#(
   parameter int HDR_WORDS = 4,
   parameter int MIN_WORDS = 15,
   parameter int LEN_W     = 16,
   parameter int GAP_VAL   = 1,
   localparam int SEL_W    = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              out_ready,
   input  logic              pk_valid,
   input  logic [WORD_W-1:0] pk_word,
   input  logic              pk_last,
   input  logic [2:0]        pk_nbytes,
   input  logic [WORD_W-1:0] hdr_word,
   output logic              pk_en,
   output logic              pk_take,
   output logic              hdr_cap,
   output logic [SEL_W-1:0]  hdr_sel,
   output logic              wr_valid,
   output logic [WORD_W-1:0] wr_data,
   output logic              ctl_valid,
   output logic [WORD_W-1:0] ctl_data,
   output logic              busy
);

   localparam logic [LEN_W-1:0] MINW_L  = LEN_W'(MIN_WORDS);
   localparam logic [LEN_W-1:0] MINB_L  = LEN_W'(MIN_WORDS * 4);
   localparam logic [SEL_W-1:0] HLAST_L = SEL_W'(HDR_WORDS - 1);
   localparam logic [GAP_W-1:0] GAP_L   = GAP_W'(GAP_VAL);

   inj_state_e        st_q;
   logic [SEL_W-1:0]  hidx_q;
   logic [LEN_W-1:0]  wcnt_q;
   logic [LEN_W-1:0]  bcnt_q;
   logic [1:0]        vld_q;
   logic [LEN_W-1:0]  bsum;
   logic [LEN_W-1:0]  wnext;

   assign bsum    = bcnt_q + LEN_W'(pk_nbytes);
   assign wnext   = wcnt_q + LEN_W'(1);
   assign hdr_sel = hidx_q;
   assign pk_en   = (st_q == ST_PAY);
   assign busy    = (st_q != ST_IDLE);

   always_comb begin
      wr_valid  = 1'b0;
      wr_data   = '0;
      ctl_valid = 1'b0;
      ctl_data  = '0;
      pk_take   = 1'b0;
      hdr_cap   = 1'b0;
      unique case (st_q)
         ST_SOF: begin
            ctl_valid = 1'b1;
            ctl_data  = ctl_word(GAP_L, 1'b1, 1'b0, 2'd0);
            hdr_cap   = out_ready;
         end
         ST_HDR: begin
            wr_valid = 1'b1;
            wr_data  = hdr_word;
         end
         ST_PAY: begin
            wr_valid = pk_valid;
            wr_data  = pk_word;
            pk_take  = pk_valid && out_ready;
         end
         ST_PAD: wr_valid = 1'b1;
         ST_EOF: begin
            ctl_valid = 1'b1;
            ctl_data  = ctl_word(GAP_L, 1'b0, 1'b1, vld_q);
         end
         ST_CRC: wr_valid = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         hidx_q <= '0;
         wcnt_q <= '0;
         bcnt_q <= '0;
         vld_q  <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (in_valid) st_q <= ST_SOF;
            ST_SOF: if (out_ready) begin
               st_q   <= ST_HDR;
               hidx_q <= '0;
               wcnt_q <= '0;
               bcnt_q <= '0;
            end
            ST_HDR: if (out_ready) begin
               if (hidx_q == HLAST_L) st_q <= ST_PAY;
               else                   hidx_q <= hidx_q + SEL_W'(1);
            end
            ST_PAY: if (pk_take) begin
               wcnt_q <= wnext;
               bcnt_q <= bsum;
               if (pk_last) begin
                  vld_q <= (bsum < MINB_L) ? 2'd0 : bsum[1:0];
                  st_q  <= (wnext < MINW_L) ? ST_PAD : ST_EOF;
               end
            end
            ST_PAD: if (out_ready) begin
               wcnt_q <= wnext;
               if (wnext >= MINW_L) st_q <= ST_EOF;
            end
            ST_EOF: if (out_ready) st_q <= ST_CRC;
            ST_CRC: if (out_ready) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/inj_framer.sv
module inj_framer
   import inj_pkg::*;
#(
   parameter int HDR_WORDS      = 4,
   parameter int MIN_CELL_BYTES = 60,
   parameter int LEN_W          = 16,
   parameter int GAP_VAL        = 1,
   localparam int MIN_WORDS     = MIN_CELL_BYTES / 4,
   localparam int SEL_W         = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   output logic                        in_ready,
   input  logic [7:0]                  in_data,
   input  logic                        in_last,
   input  logic [HDR_WORDS*32-1:0]     hdr_in,
   input  logic                        out_ready,
   output logic                        wr_valid,
   output logic [31:0]                 wr_data,
   output logic                        ctl_valid,
   output logic [31:0]                 ctl_data,
   output logic                        busy
);

   if (HDR_WORDS < 1) begin : g_bad_hdr
      $error("inj_framer: HDR_WORDS must be at least 1");
   end
   if (MIN_CELL_BYTES < 4 || (MIN_CELL_BYTES % 4) != 0) begin : g_bad_cell
      $error("inj_framer: MIN_CELL_BYTES must be a positive multiple of 4");
   end
   if (GAP_VAL < 0 || GAP_VAL >= (1 << GAP_W)) begin : g_bad_gap
      $error("inj_framer: GAP_VAL does not fit the gap field");
   end
   if ((1 << LEN_W) <= MIN_CELL_BYTES) begin : g_bad_len
      $error("inj_framer: LEN_W too narrow for the minimum cell");
   end

   logic              pk_en, pk_take, pk_valid, pk_last;
   logic [WORD_W-1:0] pk_word;
   logic [2:0]        pk_nbytes;
   logic              hdr_cap;
   logic [SEL_W-1:0]  hdr_sel;
   logic [WORD_W-1:0] hdr_word;

   inj_packer u_pack (
      .clk, .rst_n,
      .en        (pk_en),
      .in_valid,
      .in_ready,
      .in_data,
      .in_last,
      .take      (pk_take),
      .pk_valid,
      .pk_word,
      .pk_last,
      .pk_nbytes
   );

   inj_hdr_store #(.HDR_WORDS(HDR_WORDS)) u_hdr (
      .clk, .rst_n,
      .cap    (hdr_cap),
      .hdr_in,
      .sel    (hdr_sel),
      .word   (hdr_word)
   );

   inj_seq #(
      .HDR_WORDS (HDR_WORDS),
      .MIN_WORDS (MIN_WORDS),
      .LEN_W     (LEN_W),
      .GAP_VAL   (GAP_VAL)
   ) u_seq (
      .clk, .rst_n,
      .in_valid,
      .out_ready,
      .pk_valid,
      .pk_word,
      .pk_last,
      .pk_nbytes,
      .hdr_word,
      .pk_en,
      .pk_take,
      .hdr_cap,
      .hdr_sel,
      .wr_valid,
      .wr_data,
      .ctl_valid,
      .ctl_data,
      .busy
   );

endmodule

// File: rtl/inj_framer_chk.sv
module inj_framer_chk #(
   parameter int GAP_VAL = 1
)(
   input logic        clk,
   input logic        rst_n,
   input logic        in_ready,
   input logic        out_ready,
   input logic        wr_valid,
   input logic [31:0] wr_data,
   input logic        ctl_valid,
   input logic [31:0] ctl_data,
   input logic        busy
);

   // R9
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_valid && ctl_valid));

   // R9
   in_ready_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_valid |-> !in_ready);

   // R8
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !out_ready) |=> (wr_valid && $stable(wr_data)));

   // R8
   ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_valid && !out_ready) |=> (ctl_valid && $stable(ctl_data)));

   // R10
   strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid || ctl_valid || in_ready) |-> busy);

   // R2
   ctl_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_valid |-> ((ctl_data[23:21] == 3'(GAP_VAL)) && (ctl_data[18] != ctl_data[19])));

   // R3
   hdr_after_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_valid && out_ready && ctl_data[18]) |=> (wr_valid && !ctl_valid));

   // R7
   crc_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_valid && out_ready && ctl_data[19]) |=> (wr_valid && wr_data == 32'd0));

endmodule

bind inj_framer inj_framer_chk #(.GAP_VAL(GAP_VAL)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .out_ready (out_ready),
   .wr_valid  (wr_valid),
   .wr_data   (wr_data),
   .ctl_valid (ctl_valid),
   .ctl_data  (ctl_data),
   .busy      (busy)
);

// File: tb/sim_inj_framer.sv
module sim_inj_framer;

   localparam int CLK_PERIOD = 10;
   localparam int HW         = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic            in_ready;
   logic [7:0]      in_data = '0;
   logic            in_last = 1'b0;
   logic [HW*32-1:0] hdr_in = '0;
   logic            out_ready = 1'b1;
   logic            wr_valid;
   logic [31:0]     wr_data;
   logic            ctl_valid;
   logic [31:0]     ctl_data;
   logic            busy;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit bp_mode = 1'b0;
   bit done = 1'b0;

   logic [32:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   inj_framer #(.HDR_WORDS(HW)) u0 (
      .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_last, .hdr_in,
      .out_ready, .wr_valid, .wr_data, .ctl_valid, .ctl_data, .busy
   );

   task automatic check(input bit ok, input string tag,
                        input logic [32:0] act, input logic [32:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   function automatic logic [7:0] byte_of(input int seed, input int i);
      return 8'((seed + i * 13) & 8'hFF);
   endfunction

   // Reference model: expected write sequence for one frame.
   task automatic predict(input int len, input int seed);
      int nw;
      int sent;
      int vld;
      exp_q.push_back({1'b1, 32'h0024_0000}); tag_q.push_back("R2");
      for (int k = 0; k < HW; k++) begin
         exp_q.push_back({1'b0, hdr_in[k*32 +: 32]}); tag_q.push_back("R3");
      end
      nw = (len + 3) / 4;
      for (int w = 0; w < nw; w++) begin
         logic [31:0] word;
         word = '0;
         for (int b = 0; b < 4; b++)
            if (w * 4 + b < len) word[b*8 +: 8] = byte_of(seed, w * 4 + b);
         exp_q.push_back({1'b0, word}); tag_q.push_back("R4");
      end
      sent = nw;
      while (sent < 15) begin
         exp_q.push_back({1'b0, 32'd0}); tag_q.push_back("R5");
         sent++;
      end
      vld = (len < 60) ? 0 : (len % 4);
      exp_q.push_back({1'b1, 32'h0028_0000 | (32'(vld) << 16)}); tag_q.push_back("R6");
      exp_q.push_back({1'b0, 32'd0}); tag_q.push_back("R7");
   endtask

   task automatic send_frame(input int len, input int seed);
      for (int k = 0; k < HW; k++) hdr_in[k*32 +: 32] = 32'hC0DE_0000 + 32'(seed * 16 + k);
      predict(len, seed);
      for (int i = 0; i < len; i++) begin
         in_valid = 1'b1;
         in_data  = byte_of(seed, i);
         in_last  = (i == len - 1);
         @(negedge clk);
         while (!in_ready) @(negedge clk);
         @(posedge clk); #1;
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   // Backpressure driver
   initial begin
      forever begin
         @(posedge clk); #1;
         out_ready = bp_mode ? (($urandom % 3) != 0) : 1'b1;
      end
   end

   // Monitor: compare every accepted write with the model
   bit          in_frame = 1'b0;
   bit          just_ended = 1'b0;
   bit          prev_stall = 1'b0;
   logic [32:0] prev_item = '0;

   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (cyc > 150000 && !done) begin
            check(1'b0, "watchdog", 33'(cyc), 33'd0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
         if (rst_n) begin
            if (wr_valid && ctl_valid)
               check(1'b0, "R9 both strobes", {wr_valid, 32'(ctl_valid)}, 33'd0);
            if (ctl_valid && in_ready)
               check(1'b0, "R9 in_ready with control", 33'd1, 33'd0);
            if (just_ended) begin
               check(busy == 1'b0, "R7 idle after checksum", 33'(busy), 33'd0);
               just_ended = 1'b0;
            end
            if (in_frame)
               check(busy == 1'b1, "R10 busy in frame", 33'(busy), 33'd1);
            if (prev_stall)
               check((wr_valid || ctl_valid) &&
                     {ctl_valid, ctl_valid ? ctl_data : wr_data} == prev_item,
                     "R8 held while stalled",
                     {ctl_valid, ctl_valid ? ctl_data : wr_data}, prev_item);
            prev_stall = (wr_valid || ctl_valid) && !out_ready;
            prev_item  = {ctl_valid, ctl_valid ? ctl_data : wr_data};
            if ((wr_valid || ctl_valid) && out_ready) begin
               if (exp_q.size() == 0) begin
                  check(1'b0, "unexpected write", prev_item, 33'd0);
               end else begin
                  logic [32:0] e;
                  string t;
                  e = exp_q.pop_front();
                  t = tag_q.pop_front();
                  check(prev_item == e, t, prev_item, e);
                  if (t == "R2") in_frame = 1'b1;
                  if (t == "R7") begin in_frame = 1'b0; just_ended = 1'b1; end
               end
            end
         end
      end
   end

   task automatic wait_drain();
      while (exp_q.size() != 0 || busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(!busy && !wr_valid && !ctl_valid && !in_ready, "R1 reset state",
            {busy, 29'd0, wr_valid, ctl_valid, in_ready}, 33'd0);
      @(posedge clk); #1;
      send_frame(1, 3);   wait_drain();
      send_frame(3, 20);  wait_drain();
      send_frame(4, 41);  wait_drain();
      send_frame(56, 7);  wait_drain();
      send_frame(57, 9);  wait_drain();
      send_frame(59, 11); wait_drain();
      send_frame(60, 13); wait_drain();
      send_frame(61, 17); wait_drain();
      send_frame(62, 19); wait_drain();
      send_frame(63, 23); wait_drain();
      send_frame(100, 29); wait_drain();
      // back-to-back frames, no drain in between
      send_frame(5, 31);
      send_frame(66, 37);
      wait_drain();
      // R8: random backpressure
      bp_mode = 1'b1;
      send_frame(2, 43);
      send_frame(64, 47);
      send_frame(73, 53);
      send_frame(30, 59);
      wait_drain();
      bp_mode = 1'b0;
      repeat (4) @(negedge clk);
      check(!busy && !wr_valid && !ctl_valid, "R7 final idle",
            {busy, 30'd0, wr_valid, ctl_valid}, 33'd0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule